// File: doc/BRIEF.md
# ICV Check Completion Reporter

This block closes out each job of a crypto execution unit. When a job ends it compares the integrity check value the engine computed with the one supplied alongside the data. It then decides how completion and the pass/fail result leave the block: as a status writeback request together with a done interrupt, as a done interrupt alone, or, when the check fails and interrupt reporting is selected, as an error interrupt alone. The pass/fail outcome always travels on exactly one path.

The block also owns a small mode register. Its low nibble sets how many bytes of the check value take part in the comparison. The register rejects illegal programming. A write that sets a reserved bit raises a data error, and a write while a job is running raises a context error. Either error raises the error interrupt at once and cancels the done signaling of the job it belongs to. Sticky status bits record completion, check failure and both error kinds until software clears them.

Top module: `icv_report_ctrl`

## Requirements
- R1: After synchronous reset, all three interrupt/request outputs are low, `status_o` is 0 and `mode_o` is 0.
- R2: A mode write (`cfg_we_i`=1, `cfg_sel_i`=0) while idle with bit 7 clear loads `cfg_wdata_i` into `mode_o` on the next cycle. `reinit_i` clears the mode register to 0 and takes priority over a mode write in the same cycle, which is then dropped with no error.
- R3: A mode write while idle with bit 7 set leaves the mode register unchanged, pulses `err_irq_o` for one cycle on the next cycle and sets `status_o[2]` (data error).
- R4: A mode write while a job is running leaves the mode register unchanged, pulses `err_irq_o` on the next cycle and sets `status_o[3]` (context error).
- R5: With `mode_o[3:0]`=N-1, only bytes 0..N-1 are compared (byte k is bits 8k+7..8k). A difference in a higher byte is not a mismatch. With `icv_chk_en_i` low the job always counts as matching.
- R6: If `wb_en_a_i` or `wb_en_b_i` is set when a job ends, whatever the mask, `done_irq_o` and `wb_req_o` pulse on the next cycle. `status_o[0]` (done) is set, and `status_o[1]` (check failed) is set exactly when the values mismatch.
- R7: If both writeback enables and `icv_err_mask_i` are low and the values match, `done_irq_o` pulses, `wb_req_o` stays low and `status_o[0]` is set.
- R8: If both writeback enables and `icv_err_mask_i` are low and the values mismatch, only `err_irq_o` pulses. There is no done pulse and no writeback, and `status_o` does not change.
- R9: With `icv_err_mask_i` high and both writeback enables low, a job ends with a normal done pulse and no writeback, and a mismatch is reported nowhere.
- R10: A data or context error raised since the previous job end, including one raised in the job-end cycle itself, suppresses done, writeback and done status for the job that ends next. The pending error is then forgotten.
- R11: Status bits are sticky. A write with `cfg_sel_i`=1 clears every status bit whose `cfg_wdata_i[3:0]` bit is 1, and a bit set in the same cycle wins over its clear.
- R12: `job_start_i` while running and `job_end_i` while idle are ignored. Every output pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reinit_i | input | 1 | Clears the mode register |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | 0: mode register, 1: status clear |
| cfg_wdata_i | input | 8 | Write data |
| job_start_i | input | 1 | Job begins |
| job_end_i | input | 1 | Job ends; check values valid |
| icv_chk_en_i | input | 1 | Enables the comparison |
| icv_calc_i | input | 128 | Computed check value |
| icv_ref_i | input | 128 | Supplied check value |
| wb_en_a_i | input | 1 | Writeback enable A |
| wb_en_b_i | input | 1 | Writeback enable B |
| icv_err_mask_i | input | 1 | Masks the check-error interrupt |
| done_irq_o | output | 1 | Done interrupt pulse |
| err_irq_o | output | 1 | Error interrupt pulse |
| wb_req_o | output | 1 | Status writeback request pulse |
| status_o | output | 4 | {ctx err, data err, check failed, done} |
| mode_o | output | 8 | Mode register contents |

## Verification
Several properties hold on every cycle. Done and error pulses never coincide, a writeback request never comes without a done pulse, done pulses are single cycles caused by a job end, and the check-failed status only rises when a writeback enable is set. A rejected mode write, whether for a reserved bit or during a job, leaves the mode register unchanged, and a reinitialization always clears it. Other behaviour can only be shown by the bench's scenarios against its cycle model. These are the byte-length masking, the choice between the three reporting paths, the suppression of a job by an earlier error, and the set-over-clear order of the status bits.

// File: rtl/icv_pkg.sv
`timescale 1ns/1ps
package icv_pkg;

    // Sticky status word, bit 0 is completion.
    typedef struct packed {
        logic ctx_err;
        logic data_err;
        logic icv_fail;
        logic done;
    } icv_stat_t;

    localparam int STAT_W = $bits(icv_stat_t);

    // Where the pass/fail outcome of a job is reported.
    typedef enum logic [1:0] {
        PATH_WB     = 2'd0,
        PATH_IRQ    = 2'd1,
        PATH_SILENT = 2'd2
    } rpt_path_e;

    // Single-cycle event outputs.
    typedef struct packed {
        logic done;
        logic err;
        logic wb;
    } pulse_t;

    function automatic rpt_path_e pick_path(input logic wa, input logic wb, input logic mask);
        if (wa || wb)
            return PATH_WB;
        else if (!mask)
            return PATH_IRQ;
        else
            return PATH_SILENT;
    endfunction

endpackage

// File: rtl/icv_mode_reg.sv
`timescale 1ns/1ps
module icv_mode_reg #(
    parameter int                MODE_W    = 8,
    parameter logic [MODE_W-1:0] RSVD_MASK = 8'h80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reinit_i,
    input  logic              wr_en_i,
    input  logic [MODE_W-1:0] wdata_i,
    input  logic              busy_i,
    output logic [MODE_W-1:0] mode_o,
    output logic              data_err_o,
    output logic              ctx_err_o
);

    logic [MODE_W-1:0] mode_q;
    logic              rsvd_hit;
    logic              load;

    always_comb begin
        rsvd_hit   = |(wdata_i & RSVD_MASK);
        ctx_err_o  = wr_en_i && !reinit_i && busy_i;
        data_err_o = wr_en_i && !reinit_i && !busy_i && rsvd_hit;
        load       = wr_en_i && !reinit_i && !busy_i && !rsvd_hit;
    end

    always_ff @(posedge clk) begin
        if (rst || reinit_i)
            mode_q <= '0;
        else if (load)
            mode_q <= wdata_i;
    end

    assign mode_o = mode_q;

    // R4
    ctx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ctx_err_o |=> $stable(mode_q));

    // R3
    rsvd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        data_err_o |=> $stable(mode_q));

    // R2
    reinit_clr_chk: assert property (@(posedge clk) disable iff (rst)
        reinit_i |=> (mode_q == '0));

endmodule

// File: rtl/icv_byte_cmp.sv
`timescale 1ns/1ps
module icv_byte_cmp #(
    parameter int BYTES = 16,
    parameter int LEN_W = $clog2(BYTES)
) (
    input  logic [BYTES*8-1:0] a_i,
    input  logic [BYTES*8-1:0] b_i,
    input  logic [LEN_W-1:0]   len_m1_i,
    input  logic               en_i,
    output logic               mismatch_o
);

    logic [BYTES-1:0] diff;

    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        localparam logic [LEN_W:0] IDX = (LEN_W+1)'(i);
        assign diff[i] = (a_i[8*i +: 8] != b_i[8*i +: 8]) && (IDX <= {1'b0, len_m1_i});
    end

    assign mismatch_o = en_i && (|diff);

endmodule

// File: rtl/icv_report_ctrl.sv
`timescale 1ns/1ps
module icv_report_ctrl
    import icv_pkg::*;
#(
    parameter int ICV_BYTES = 16,
    parameter int MODE_W    = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reinit_i,
    input  logic                   cfg_we_i,
    input  logic                   cfg_sel_i,
    input  logic [MODE_W-1:0]      cfg_wdata_i,
    input  logic                   job_start_i,
    input  logic                   job_end_i,
    input  logic                   icv_chk_en_i,
    input  logic [ICV_BYTES*8-1:0] icv_calc_i,
    input  logic [ICV_BYTES*8-1:0] icv_ref_i,
    input  logic                   wb_en_a_i,
    input  logic                   wb_en_b_i,
    input  logic                   icv_err_mask_i,
    output logic                   done_irq_o,
    output logic                   err_irq_o,
    output logic                   wb_req_o,
    output logic [STAT_W-1:0]      status_o,
    output logic [MODE_W-1:0]      mode_o
);

    localparam int                LEN_W     = $clog2(ICV_BYTES);
    localparam logic [MODE_W-1:0] RSVD_MASK = {MODE_W{1'b1}} << (LEN_W + 3);

    logic      busy_q, busy_n;
    logic      fault_q, fault_n, fault_now;
    icv_stat_t stat_q, stat_n;
    pulse_t    pulse_q, pulse_n;
    logic      derr, cerr, mismatch, ending, stat_clr;
    rpt_path_e path;
    logic [MODE_W-1:0] mode_q;

    icv_mode_reg #(.MODE_W(MODE_W), .RSVD_MASK(RSVD_MASK)) u_mode (
        .clk        (clk),
        .rst        (rst),
        .reinit_i   (reinit_i),
        .wr_en_i    (cfg_we_i && !cfg_sel_i),
        .wdata_i    (cfg_wdata_i),
        .busy_i     (busy_q),
        .mode_o     (mode_q),
        .data_err_o (derr),
        .ctx_err_o  (cerr)
    );

    icv_byte_cmp #(.BYTES(ICV_BYTES), .LEN_W(LEN_W)) u_cmp (
        .a_i        (icv_calc_i),
        .b_i        (icv_ref_i),
        .len_m1_i   (mode_q[LEN_W-1:0]),
        .en_i       (icv_chk_en_i),
        .mismatch_o (mismatch)
    );

    always_comb begin
        ending    = busy_q && job_end_i;
        stat_clr  = cfg_we_i && cfg_sel_i;
        fault_now = fault_q || derr || cerr;
        path      = pick_path(wb_en_a_i, wb_en_b_i, icv_err_mask_i);

        stat_n = stat_q;
        if (stat_clr)
            stat_n = stat_q & ~icv_stat_t'(cfg_wdata_i[STAT_W-1:0]);
        if (derr) stat_n.data_err = 1'b1;
        if (cerr) stat_n.ctx_err  = 1'b1;

        pulse_n     = '0;
        pulse_n.err = derr || cerr;
        fault_n     = fault_now;
        busy_n      = busy_q;

        if (ending) begin
            busy_n  = 1'b0;
            fault_n = 1'b0;
            if (!fault_now) begin
                if (path == PATH_IRQ && mismatch) begin
                    pulse_n.err = 1'b1;
                end else begin
                    pulse_n.done = 1'b1;
                    pulse_n.wb   = (path == PATH_WB);
                    stat_n.done  = 1'b1;
                    if (path == PATH_WB && mismatch)
                        stat_n.icv_fail = 1'b1;
                end
            end
        end else if (!busy_q && job_start_i) begin
            busy_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            fault_q <= 1'b0;
            stat_q  <= '0;
            pulse_q <= '0;
        end else begin
            busy_q  <= busy_n;
            fault_q <= fault_n;
            stat_q  <= stat_n;
            pulse_q <= pulse_n;
        end
    end

    assign done_irq_o = pulse_q.done;
    assign err_irq_o  = pulse_q.err;
    assign wb_req_o   = pulse_q.wb;
    assign status_o   = stat_q;
    assign mode_o     = mode_q;

    // R8
    done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done_irq_o && err_irq_o));

    // R6
    wb_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        wb_req_o |-> done_irq_o);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_irq_o |=> !done_irq_o);

    // R10
    done_src_chk: assert property (@(posedge clk) disable iff (rst)
        done_irq_o |-> $past(job_end_i));

    // R8
    fail_path_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q.icv_fail) |-> $past(wb_en_a_i || wb_en_b_i));

endmodule

// File: tb/tb_icv_report_ctrl.sv
`timescale 1ns/1ps
module tb_icv_report_ctrl;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reinit_i = 1'b0;
    logic         cfg_we_i = 1'b0;
    logic         cfg_sel_i = 1'b0;
    logic [7:0]   cfg_wdata_i = '0;
    logic         job_start_i = 1'b0;
    logic         job_end_i = 1'b0;
    logic         icv_chk_en_i = 1'b0;
    logic [127:0] icv_calc_i = '0;
    logic [127:0] icv_ref_i = '0;
    logic         wb_en_a_i = 1'b0;
    logic         wb_en_b_i = 1'b0;
    logic         icv_err_mask_i = 1'b0;
    logic         done_irq_o, err_irq_o, wb_req_o;
    logic [3:0]   status_o;
    logic [7:0]   mode_o;

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";
    bit    finished = 0;

    localparam logic [127:0] BASE = 128'h00112233445566778899aabbccddeeff;

    always #10 clk = ~clk;

    icv_report_ctrl dut (
        .clk(clk), .rst(rst), .reinit_i(reinit_i),
        .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
        .job_start_i(job_start_i), .job_end_i(job_end_i),
        .icv_chk_en_i(icv_chk_en_i), .icv_calc_i(icv_calc_i), .icv_ref_i(icv_ref_i),
        .wb_en_a_i(wb_en_a_i), .wb_en_b_i(wb_en_b_i), .icv_err_mask_i(icv_err_mask_i),
        .done_irq_o(done_irq_o), .err_irq_o(err_irq_o), .wb_req_o(wb_req_o),
        .status_o(status_o), .mode_o(mode_o)
    );

    // Behavioural reference model
    logic [7:0] m_mode;
    bit         m_busy, m_fault;
    logic [3:0] m_stat;
    bit         x_done, x_err, x_wb;

    function automatic bit differs(input logic [127:0] a, input logic [127:0] b, input int n);
        for (int k = 0; k < n; k++)
            if (a[8*k +: 8] != b[8*k +: 8]) return 1'b1;
        return 1'b0;
    endfunction

    always @(posedge clk) begin : model
        bit ed, ec, mis, wbm, irqm, flt;
        int len;
        if (rst) begin
            m_mode = 0; m_busy = 0; m_fault = 0; m_stat = 0;
            x_done = 0; x_err = 0; x_wb = 0;
        end else begin
            ed = 0; ec = 0; x_done = 0; x_err = 0; x_wb = 0;
            len = int'(m_mode[3:0]) + 1;
            mis = icv_chk_en_i && differs(icv_calc_i, icv_ref_i, len);
            wbm  = wb_en_a_i || wb_en_b_i;
            irqm = !wbm && !icv_err_mask_i;
            if (cfg_we_i && cfg_sel_i) m_stat = m_stat & ~cfg_wdata_i[3:0];
            if (reinit_i) m_mode = 0;
            else if (cfg_we_i && !cfg_sel_i) begin
                if (m_busy) ec = 1;
                else if (cfg_wdata_i[7]) ed = 1;
                else m_mode = cfg_wdata_i;
            end
            if (ed) m_stat[2] = 1;
            if (ec) m_stat[3] = 1;
            x_err = ed || ec;
            flt = m_fault || ed || ec;
            if (m_busy && job_end_i) begin
                m_busy = 0; m_fault = 0;
                if (!flt) begin
                    if (irqm && mis) x_err = 1;
                    else begin
                        x_done = 1; x_wb = wbm; m_stat[0] = 1;
                        if (wbm && mis) m_stat[1] = 1;
                    end
                end
            end else begin
                m_fault = flt;
                if (!m_busy && job_start_i) m_busy = 1;
            end
        end
    end

    task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            check("done_irq", {7'b0, done_irq_o}, {7'b0, x_done});
            check("err_irq",  {7'b0, err_irq_o},  {7'b0, x_err});
            check("wb_req",   {7'b0, wb_req_o},   {7'b0, x_wb});
            check("status",   {4'b0, status_o},   {4'b0, m_stat});
            check("mode",     mode_o,             m_mode);
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #5;
        end
    endtask

    task automatic wr(input bit sel, input logic [7:0] d);
        cfg_we_i = 1; cfg_sel_i = sel; cfg_wdata_i = d;
        step();
        cfg_we_i = 0; cfg_sel_i = 0; cfg_wdata_i = '0;
    endtask

    task automatic job(input bit en, input logic [127:0] a, input logic [127:0] b);
        job_start_i = 1; step(); job_start_i = 0;
        step(2);
        icv_chk_en_i = en; icv_calc_i = a; icv_ref_i = b; job_end_i = 1;
        step();
        job_end_i = 0; icv_chk_en_i = 0;
        step(2);
    endtask

    task automatic paths(input bit a, input bit b, input bit m);
        wb_en_a_i = a; wb_en_b_i = b; icv_err_mask_i = m;
    endtask

    function automatic logic [127:0] flip(input int k);
        return BASE ^ (128'hFF << (8*k));
    endfunction

    initial begin : watchdog
        #4000000;
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        cur_req = "R1";
        step(3); rst = 0; step(2);

        // R2 mode load, reinit priority
        cur_req = "R2";
        wr(0, 8'h7F); step();
        reinit_i = 1; cfg_we_i = 1; cfg_wdata_i = 8'h05; step();
        reinit_i = 0; cfg_we_i = 0; cfg_wdata_i = 0; step();
        wr(0, 8'h0F); step();

        // R6 writeback path, mismatch in top byte
        cur_req = "R6";
        paths(1, 0, 0); job(1, BASE, flip(15));
        paths(0, 1, 1); job(1, BASE, BASE);
        // R11 clear all
        cur_req = "R11"; wr(1, 8'h0F); step();

        // R5 length 4 bytes
        cur_req = "R5";
        wr(0, 8'h03); paths(0, 0, 0);
        job(1, BASE, flip(5));
        job(0, BASE, flip(0));
        // R8 mismatch inside the length
        cur_req = "R8";
        job(1, BASE, flip(3));
        // R7 interrupt path match
        cur_req = "R7";
        wr(1, 8'h0F); wr(0, 8'h0F);
        job(1, flip(7), flip(7));
        cur_req = "R8";
        job(1, BASE, flip(9));
        // R9 silent path
        cur_req = "R9";
        paths(0, 0, 1); job(1, BASE, flip(2));

        // R3 reserved bit, then R10 suppression
        cur_req = "R3";
        wr(0, 8'h82); step();
        cur_req = "R10";
        paths(1, 0, 0); job(1, BASE, flip(1));
        job(1, BASE, flip(1));

        // R4 write during job
        cur_req = "R4";
        wr(1, 8'h0F);
        job_start_i = 1; step(); job_start_i = 0;
        wr(0, 8'h01); step();
        cur_req = "R10";
        job_end_i = 1; icv_chk_en_i = 1; icv_calc_i = BASE; icv_ref_i = BASE; step();
        job_end_i = 0; icv_chk_en_i = 0; step(2);
        // context error in the job-end cycle itself
        job_start_i = 1; step(); job_start_i = 0; step();
        job_end_i = 1; cfg_we_i = 1; cfg_sel_i = 0; cfg_wdata_i = 8'h02; step();
        job_end_i = 0; cfg_we_i = 0; cfg_wdata_i = 0; step(2);

        // R11 set wins over clear
        cur_req = "R11";
        wr(1, 8'h0F);
        job_start_i = 1; step(); job_start_i = 0; step();
        job_end_i = 1; cfg_we_i = 1; cfg_sel_i = 1; cfg_wdata_i = 8'h0F; step();
        job_end_i = 0; cfg_we_i = 0; cfg_sel_i = 0; cfg_wdata_i = 0; step(2);

        // R12 ignored strobes
        cur_req = "R12";
        job_end_i = 1; step(); job_end_i = 0; step();
        job_start_i = 1; step(); step(); step(); job_start_i = 0;
        job_end_i = 1; step(); job_end_i = 0; step();
        job_end_i = 1; step(); job_end_i = 0; step(3);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule